// File: doc/BRIEF.md
# Bit-Field and Bit-Count Unit

This is a 32-bit execution unit for bit-level work. It takes a field out of a source word, either right-aligned with zero fill or with sign fill. It can also drop the low bits of a source into a field of a destination word. It counts leading zeros or set bits, and it forms the absolute value or the negated absolute value of a word. The field is given by a start position and a length. A field that would run past bit 31 is cut off at the top of the word.

Operands enter on a valid/ready stream and the result leaves on another one. The result sits in a single output register. When the consumer holds `out_ready` low, that register keeps its value and the unit stops accepting input. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A beat is accepted in any cycle where `in_valid` and `in_ready` are both high. The output beat is transferred when `out_valid` and `out_ready` are both high.

Top module: `bitfield_unit`

## Requirements
- R1: Operation code 0 (zero-filled extract) returns source bits start..start+n-1 in result bits 0..n-1, with every higher result bit 0. Here n is the effective length.
- R2: Operation code 1 (sign-filled extract) places the field as in R1 and fills every higher result bit with the most significant extracted bit.
- R3: Operation code 2 (insert) writes source bits 0..n-1 into destination bits start..start+n-1 and passes every other destination bit through unchanged.
- R4: The effective length n is the smaller of the length input and 32 minus start. Field bits that would fall above bit 31 are dropped, and sign fill uses the highest bit actually extracted.
- R5: A length of 0 makes both extracts return 0 and makes insert return the destination unchanged.
- R6: Operation code 3 returns the number of leading zero bits of the source, from 0 to 32 (32 for a zero source).
- R7: Operation code 4 returns the number of set bits of the source, from 0 to 32.
- R8: Operation code 5 returns the absolute value of the source and code 6 returns its negated absolute value. Both use two's-complement wraparound, so 0x80000000 gives 0x80000000 for each.
- R9: Operation code 7 returns 0.
- R10: An accepted beat produces `out_valid` high with its result after exactly one clock edge, provided the output register was free.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid` and `out_result` hold. `in_ready` equals `!out_valid || out_ready`.
- R12: While reset is asserted, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_op | input | 3 | Operation code (0..7, see R1-R9) |
| in_src | input | 32 | Source operand |
| in_dst | input | 32 | Current destination value, used by insert |
| in_start | input | 5 | Field start bit |
| in_len | input | 6 | Field length, 0..63 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Result word |

## Verification
The assertions check the stream rules on every cycle: hold under back-pressure, how ready is derived, one-cycle latency and the reset state. They also check a few result properties that can be stated locally: count results never exceed 32, a zero-length extract yields zero and a zero-length insert returns the destination. The field values themselves, clipping at the top of the word, the sign source after clipping and the abs wraparound on the most negative value can only be shown by the bench. It compares each result against a bit-by-bit model over directed corners and random operands.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [2:0] {
    OP_EXTZ = 3'd0,
    OP_EXTS = 3'd1,
    OP_INS  = 3'd2,
    OP_LZC  = 3'd3,
    OP_POP  = 3'd4,
    OP_ABS  = 3'd5,
    OP_NABS = 3'd6,
    OP_RSV  = 3'd7
  } bfu_op_e;
endpackage

// File: rtl/bfu_field.sv
module bfu_field #(
  parameter int W = 32,
  localparam int SHW = $clog2(W),
  localparam int LENW = SHW + 1
) (
  input  logic [W-1:0]    src,
  input  logic [W-1:0]    dst,
  input  logic [SHW-1:0]  start,
  input  logic [LENW-1:0] len,
  output logic [W-1:0]    ext_zero,
  output logic [W-1:0]    ext_sign,
  output logic [W-1:0]    inserted
);
  logic [W-1:0] mask;
  logic [W-1:0] shifted;
  logic         top_bit;
  int           eff;

  // Effective length after clipping at the top of the word.
  always_comb begin
    eff = int'(len);
    if (eff > W - int'(start)) eff = W - int'(start);
    for (int i = 0; i < W; i++) mask[i] = (i < eff);
  end

  always_comb begin
    shifted  = src >> start;
    top_bit  = (eff > 0) ? shifted[eff-1] : 1'b0;
    ext_zero = shifted & mask;
    ext_sign = ext_zero | (top_bit ? ~mask : '0);
    inserted = (dst & ~(mask << start)) | ((src & mask) << start);
  end
endmodule

// File: rtl/bfu_count.sv
module bfu_count #(
  parameter int W = 32,
  localparam int CNTW = $clog2(W + 1)
) (
  input  logic [W-1:0]    src,
  output logic [CNTW-1:0] lead_zeros,
  output logic [CNTW-1:0] ones
);
  always_comb begin
    logic seen;
    seen = 1'b0;
    lead_zeros = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (src[i]) seen = 1'b1;
      else if (!seen) lead_zeros = lead_zeros + CNTW'(1);
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + CNTW'(src[i]);
  end
endmodule

// File: rtl/bfu_arith.sv
module bfu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] magnitude,
  output logic [W-1:0] neg_magnitude
);
  logic [W-1:0] negated;
  always_comb begin
    negated       = '0 - src;
    magnitude     = src[W-1] ? negated : src;
    neg_magnitude = src[W-1] ? src : negated;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W),
  localparam int LENW = SHW + 1,
  localparam int CNTW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic [W-1:0]    in_src,
  input  logic [W-1:0]    in_dst,
  input  logic [SHW-1:0]  in_start,
  input  logic [LENW-1:0] in_len,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result
);
  logic [W-1:0]    f_extz, f_exts, f_ins, a_abs, a_nabs, next_result;
  logic [CNTW-1:0] c_lz, c_pop;

  bfu_field #(.W(W)) u_field (
    .src(in_src), .dst(in_dst), .start(in_start), .len(in_len),
    .ext_zero(f_extz), .ext_sign(f_exts), .inserted(f_ins)
  );

  bfu_count #(.W(W)) u_count (
    .src(in_src), .lead_zeros(c_lz), .ones(c_pop)
  );

  bfu_arith #(.W(W)) u_arith (
    .src(in_src), .magnitude(a_abs), .neg_magnitude(a_nabs)
  );

  always_comb begin
    unique case (bfu_op_e'(in_op))
      OP_EXTZ: next_result = f_extz;
      OP_EXTS: next_result = f_exts;
      OP_INS:  next_result = f_ins;
      OP_LZC:  next_result = W'(c_lz);
      OP_POP:  next_result = W'(c_pop);
      OP_ABS:  next_result = a_abs;
      OP_NABS: next_result = a_nabs;
      default: next_result = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_result <= next_result;
    end
  end
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker
  import bfu_pkg::*;
#(
  parameter int W = 32,
  localparam int LENW = $clog2(W) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2:0]      in_op,
  input logic [W-1:0]    in_dst,
  input logic [LENW-1:0] in_len,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W-1:0]    out_result
);
  logic accept;
  assign accept = in_valid && in_ready;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) == in_ready);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);

  p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op == OP_LZC || in_op == OP_POP)) |=> (out_result <= W));

  p_zero_len_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op == OP_EXTZ || in_op == OP_EXTS) && in_len == '0) |=> (out_result == '0));

  p_zero_len_ins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_INS && in_len == '0) |=> (out_result == $past(in_dst)));

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_RSV) |=> (out_result == '0));

  always @(posedge clk) begin
    if (!rst_n) p_reset_r12: assert (in_ready);
  end
endmodule

bind bitfield_unit bfu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_dst(in_dst), .in_len(in_len), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result)
);

// File: tb/bitfield_unit_tb.sv
module bitfield_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [31:0] in_src = '0, in_dst = '0;
  logic [4:0]  in_start = '0;
  logic [5:0]  in_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bitfield_unit u_dut (.*);

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] s, d,
                                        input int st, input int ln);
    logic [31:0] r;
    int n, cnt;
    r = '0; n = 0; cnt = 0;
    case (op)
      3'd0, 3'd1: begin
        for (int i = 0; i < 32; i++)
          if (i < ln && st + i < 32) begin r[i] = s[st+i]; n = i + 1; end
        if (op == 3'd1 && n > 0 && r[n-1])
          for (int i = n; i < 32; i++) r[i] = 1'b1;
      end
      3'd2: begin
        r = d;
        for (int i = 0; i < 32; i++) if (i < ln && st + i < 32) r[st+i] = s[i];
      end
      3'd3: begin
        for (int i = 31; i >= 0 && !s[i]; i--) cnt++;
        r = 32'(cnt);
      end
      3'd4: begin
        for (int i = 0; i < 32; i++) if (s[i]) cnt++;
        r = 32'(cnt);
      end
      3'd5: r = s[31] ? (~s + 1) : s;
      3'd6: r = s[31] ? s : (~s + 1);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] s, d, input int st, ln);
    in_valid = 1'b1; in_op = op; in_src = s; in_dst = d;
    in_start = 5'(st); in_len = 6'(ln);
  endtask

  // Drive at negedge, accept at posedge, sample at next negedge (R10).
  task automatic run(input string req, input logic [2:0] op, input logic [31:0] s, d,
                     input int st, ln, input logic [31:0] exp);
    @(negedge clk);
    drive(op, s, d, st, ln);
    @(negedge clk);
    chk("R10", 32'(out_valid), 32'd1);
    chk(req, out_result, exp);
    in_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    chk("R12", 32'(out_valid), 32'd0);
    chk("R12", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    run("R1", 3'd0, 32'hF0F0_1234, '0, 4, 8, 32'h0000_0023);
    run("R2", 3'd1, 32'h0000_0800, '0, 8, 4, 32'hFFFF_FFF8);
    run("R2", 3'd1, 32'h0000_0700, '0, 8, 4, 32'h0000_0007);
    run("R3", 3'd2, 32'h0000_0000, 32'hFFFF_FFFF, 8, 8, 32'hFFFF_00FF);
    run("R4", 3'd0, 32'h8000_0000, '0, 28, 10, 32'h0000_0008);
    run("R4", 3'd1, 32'h8000_0000, '0, 28, 63, 32'hFFFF_FFF8);
    run("R4", 3'd2, 32'h0000_000F, '0, 30, 8, 32'hC000_0000);
    run("R4", 3'd0, 32'hA5A5_A5A5, '0, 0, 32, 32'hA5A5_A5A5);
    run("R5", 3'd0, 32'hFFFF_FFFF, '0, 3, 0, 32'h0);
    run("R5", 3'd1, 32'hFFFF_FFFF, '0, 3, 0, 32'h0);
    run("R5", 3'd2, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 5, 0, 32'hDEAD_BEEF);
    run("R6", 3'd3, 32'h0, '0, 0, 0, 32'd32);
    run("R6", 3'd3, 32'h8000_0000, '0, 0, 0, 32'd0);
    run("R6", 3'd3, 32'h1, '0, 0, 0, 32'd31);
    run("R7", 3'd4, 32'hFFFF_FFFF, '0, 0, 0, 32'd32);
    run("R7", 3'd4, 32'h0, '0, 0, 0, 32'd0);
    run("R8", 3'd5, 32'h8000_0000, '0, 0, 0, 32'h8000_0000);
    run("R8", 3'd5, 32'hFFFF_FFFB, '0, 0, 0, 32'd5);
    run("R8", 3'd6, 32'd5, '0, 0, 0, 32'hFFFF_FFFB);
    run("R8", 3'd6, 32'h8000_0000, '0, 0, 0, 32'h8000_0000);
    run("R8", 3'd6, 32'h0, '0, 0, 0, 32'h0);
    run("R9", 3'd7, 32'h1234_5678, 32'hFFFF_FFFF, 1, 4, 32'h0);

    // Back-pressure (R11)
    @(negedge clk);
    out_ready = 1'b0;
    drive(3'd4, 32'h0000_00FF, '0, 0, 0);
    @(negedge clk);
    chk("R11", 32'(in_ready), 32'd0);
    chk("R11", out_result, 32'd8);
    drive(3'd3, 32'h0000_FFFF, '0, 0, 0);
    @(negedge clk);
    chk("R11", 32'(out_valid), 32'd1);
    chk("R11", out_result, 32'd8);
    out_ready = 1'b1;
    #1 chk("R11", 32'(in_ready), 32'd1);
    @(negedge clk);
    chk("R11", out_result, 32'd16);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", 32'(out_valid), 32'd0);

    // Random stimulus against the model, all requirements R1-R9 by op
    for (int k = 0; k < 600; k++) begin
      logic [2:0]  op;
      logic [31:0] s, d;
      int st, ln;
      op = 3'($urandom_range(0, 7));
      s  = $urandom();
      d  = $urandom();
      if (k % 5 == 0) s = s >> $urandom_range(0, 31);
      st = $urandom_range(0, 31);
      ln = $urandom_range(0, 63);
      run(op == 3'd0 ? "R1" : op == 3'd1 ? "R2" : op == 3'd2 ? "R3" :
          op == 3'd3 ? "R6" : op == 3'd4 ? "R7" : op == 3'd7 ? "R9" : "R8",
          op, s, d, st, ln, model(op, s, d, st, ln));
    end

    finish_run();
  end
endmodule